// File: doc/BRIEF.md
# Stepper Step Generator with Homing

This block drives a single stepper motor driver through a step line, a direction line and an active-low enable line. A one-cycle tick strobe paces all motion; between strobes only an internal divider works. After reset the block knows no position. It therefore seeks the home switch at a fixed slow target speed. When the active-low home switch reads low, it zeroes its position and declares itself homed.

Once homed, the block acts as a proportional position follower. On every tick the target speed is set to the 8-bit unsigned target input minus the signed position. The signed speed moves one unit toward that target speed on each step event and is clamped to a symmetric limit. Each step event toggles the step line and moves the position by one count. The next event is scheduled a fixed numerator divided by the absolute speed ticks later. A short restoring divider computes that quotient in the clock cycles after the event, so the tick strobe must be spaced at least a few clocks apart.

Top module: `stepper_follower`

## Requirements
- R1: While reset is held, step, dir, pos, speed and homed are 0 and en_n is 1. From the first clock after reset is released, en_n is 0.
- R2: While not homed and the target speed is zero, a tick loads a target speed of SEEK_SPEED (10) and schedules a step event for the next tick. The first tick after reset issues no step. The second tick gives speed 1 and pos 1.
- R3: A tick that sees home_n low while not homed clears pos, speed and the target speed to 0 and sets homed. Once homed is set, home_n has no effect.
- R4: Once homed, each tick sets the target speed to the unsigned target input minus pos. A change of the target speed from zero to nonzero schedules a step event for the following tick. With a steady target input, pos settles on it.
- R5: Speed changes only on a step event, by exactly one unit toward the target speed.
- R6: Speed stays within -SPEED_MAX..+SPEED_MAX (±100). A large position error drives it to exactly the limit.
- R7: After a step event that leaves speed nonzero, the next event falls INTERVAL_NUM / |speed| ticks later, using integer division and the new speed.
- R8: A step event that leaves speed nonzero toggles step. A step event that leaves speed at zero does not toggle step and does not change pos, and the next event is scheduled for the following tick.
- R9: dir is 1 after an event with positive speed and 0 after one with negative speed. It is unchanged when speed is zero.
- R10: A step event increments pos at positive speed and decrements it at negative speed.
- R11: No step events occur while the target speed is zero.
- R12: Outputs change only on clock edges where tick is high. Ticks must be at least $clog2(INTERVAL_NUM+1)+2 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle motion time-base strobe |
| home_n | input | 1 | Home switch, active low |
| target | input | TGT_W | Unsigned target position |
| step | output | 1 | Step line, toggles on each moving step event |
| dir | output | 1 | Direction, 1 for positive motion |
| en_n | output | 1 | Driver enable, active low |
| pos | output | POS_W | Signed position count |
| speed | output | SPD_W | Signed current speed |
| homed | output | 1 | Home has been found |

## Verification
The assertions check the rules that hold on every cycle:
- the speed limit;
- speed changing by one unit, and only on a tick;
- the sign of dir matching the sign of speed;
- pos moving only together with a step toggle once homed;
- the enable level after reset;
- the minimum tick spacing that the divider needs.

Only the bench's scenarios can show timing that spans many ticks. These are the exact step interval, the seek start and homing sequence, settling on a target in both directions, the zero-speed event on reversal, and reaching the speed limit. The bench compares these against a tick-level model built from the requirements.

// File: rtl/stepper_follower.sv
module stepper_follower #(
  parameter int TICK_W       = 32,
  parameter int POS_W        = 16,
  parameter int SPD_W        = 8,
  parameter int TGT_W        = 8,
  parameter int SPEED_MAX    = 100,
  parameter int SEEK_SPEED   = 10,
  parameter int INTERVAL_NUM = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    home_n,
  input  logic [TGT_W-1:0]        target,
  output logic                    step,
  output logic                    dir,
  output logic                    en_n,
  output logic signed [POS_W-1:0] pos,
  output logic signed [SPD_W-1:0] speed,
  output logic                    homed
);

  localparam int RAMP_W = POS_W + 1;
  localparam int NUM_W  = $clog2(INTERVAL_NUM + 1);
  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam logic signed [RAMP_W-1:0] MAX_R = RAMP_W'(SPEED_MAX);
  localparam logic signed [RAMP_W-1:0] MIN_R = -MAX_R;

  logic [TICK_W-1:0]        t_cnt, t_nx, next_at;
  logic signed [RAMP_W-1:0] ramp, spd_x, spd_try, ramp_new;
  logic signed [SPD_W-1:0]  spd_new;
  logic [SPD_W-1:0]         spd_mag;
  logic signed [POS_W-1:0]  pos_new, pos_after;
  logic                     due, moving;

  logic                     div_busy;
  logic [CNT_W-1:0]         div_cnt;
  logic [SPD_W-1:0]         div_rem, div_den, rem_nx;
  logic [NUM_W-2:0]         div_quo;
  logic [NUM_W-1:0]         div_num, quo_nx;
  logic [SPD_W:0]           rem_sh;
  logic                     div_ge;

  assign t_nx  = t_cnt + 1'b1;
  assign due   = (ramp != '0) && (t_nx == next_at);
  assign spd_x = RAMP_W'(speed);

  always_comb begin
    spd_try = spd_x;
    if (spd_x < ramp)      spd_try = spd_x + RAMP_W'(1);
    else if (spd_x > ramp) spd_try = spd_x - RAMP_W'(1);
    if (spd_try > MAX_R)      spd_try = MAX_R;
    else if (spd_try < MIN_R) spd_try = MIN_R;
  end

  assign spd_new   = SPD_W'(spd_try);
  assign moving    = spd_new != '0;
  assign spd_mag   = spd_new[SPD_W-1] ? $unsigned(-spd_new) : $unsigned(spd_new);
  assign pos_new   = spd_new[SPD_W-1] ? pos - POS_W'(1) : pos + POS_W'(1);
  assign pos_after = (due && moving) ? pos_new : pos;
  assign ramp_new  = RAMP_W'($signed({1'b0, target})) - RAMP_W'(pos_after);

  assign rem_sh = {div_rem, div_num[NUM_W-1]};
  assign div_ge = rem_sh >= {1'b0, div_den};
  assign rem_nx = SPD_W'(div_ge ? rem_sh - {1'b0, div_den} : rem_sh);
  assign quo_nx = {div_quo, div_ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt    <= '0;
      next_at  <= '0;
      ramp     <= '0;
      speed    <= '0;
      pos      <= '0;
      homed    <= 1'b0;
      step     <= 1'b0;
      dir      <= 1'b0;
      en_n     <= 1'b1;
      div_busy <= 1'b0;
      div_cnt  <= '0;
      div_rem  <= '0;
      div_quo  <= '0;
      div_num  <= '0;
      div_den  <= '0;
    end else begin
      en_n <= 1'b0;
      if (tick) begin
        t_cnt <= t_nx;
        if (due) begin
          speed <= spd_new;
          if (moving) begin
            dir      <= !spd_new[SPD_W-1];
            step     <= !step;
            pos      <= pos_new;
            next_at  <= t_nx;
            div_busy <= 1'b1;
            div_cnt  <= '0;
            div_rem  <= '0;
            div_quo  <= '0;
            div_num  <= NUM_W'(INTERVAL_NUM);
            div_den  <= spd_mag;
          end else begin
            next_at <= t_nx + 1'b1;
          end
        end
        if (homed) begin
          ramp <= ramp_new;
          if (ramp_new != '0 && ramp == '0) next_at <= t_nx + 1'b1;
        end else if (!home_n) begin
          pos   <= '0;
          speed <= '0;
          ramp  <= '0;
          homed <= 1'b1;
        end else if (ramp == '0) begin
          ramp    <= RAMP_W'(SEEK_SPEED);
          next_at <= t_nx + 1'b1;
        end
      end else if (div_busy) begin
        div_rem <= rem_nx;
        div_quo <= quo_nx[NUM_W-2:0];
        div_num <= div_num << 1;
        div_cnt <= div_cnt + 1'b1;
        if (div_cnt == CNT_W'(NUM_W - 1)) begin
          div_busy <= 1'b0;
          next_at  <= next_at + TICK_W'(quo_nx);
        end
      end
    end
  end

  assert_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !en_n);

  assert_speed_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (speed != $past(speed)) && !$rose(homed) |->
      ((speed - $past(speed)) == 1 || ($past(speed) - speed) == 1));

  assert_speed_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (speed <= $signed(SPEED_MAX)) && (speed >= -$signed(SPEED_MAX)));

  assert_dir_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (speed > 0) |-> dir);

  assert_dir_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (speed < 0) |-> !dir);

  assert_pos_with_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    homed && $past(homed) && (pos != $past(pos)) |-> (step != $past(step)));

  assert_change_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (speed != $past(speed) || pos != $past(pos) || step != $past(step)) |-> $past(tick));

  assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !div_busy);

endmodule

// File: tb/stepper_follower_test.sv
module stepper_follower_test;

  localparam int NUM  = 120;
  localparam int MAXS = 100;
  localparam int SEEK = 10;
  localparam int GAP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic home_n = 1'b1;
  logic [7:0] target = 8'd0;
  logic step, dir, en_n, homed;
  logic signed [15:0] pos;
  logic signed [7:0] speed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_t = 0, m_next = 0, m_ramp = 0, m_spd = 0, m_pos = 0;
  int m_homed = 0, m_step = 0, m_dir = 0;

  stepper_follower #(.INTERVAL_NUM(NUM)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .home_n(home_n), .target(target),
    .step(step), .dir(dir), .en_n(en_n), .pos(pos), .speed(speed), .homed(homed)
  );

  always #5 clk = ~clk;

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int t, s, old;
    t = m_t + 1;
    if (m_ramp != 0 && m_next == t) begin
      s = m_spd;
      if (s < m_ramp) s++;
      else if (s > m_ramp) s--;
      if (s > MAXS) s = MAXS;
      if (s < -MAXS) s = -MAXS;
      m_spd = s;
      if (s != 0) begin
        m_dir  = (s > 0) ? 1 : 0;
        m_step = 1 - m_step;
        m_pos  = m_pos + ((s > 0) ? 1 : -1);
        m_next = t + NUM / ((s > 0) ? s : -s);
      end else begin
        m_next = t + 1;
      end
    end
    if (m_homed != 0) begin
      old = m_ramp;
      m_ramp = int'(target) - m_pos;
      if (m_ramp != 0 && old == 0) m_next = t + 1;
    end else if (!home_n) begin
      m_pos = 0; m_spd = 0; m_ramp = 0; m_homed = 1;
    end else if (m_ramp == 0) begin
      m_ramp = SEEK; m_next = t + 1;
    end
    m_t = t;
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    model_step();
    repeat (GAP) @(negedge clk);
  endtask

  task automatic compare_model(input string req);
    chk_eq(req, "pos", int'(pos), m_pos);
    chk_eq(req, "speed", int'(speed), m_spd);
    chk_eq(req, "step", int'(step), m_step);
    chk_eq(req, "dir", int'(dir), m_dir);
    chk_eq(req, "homed", int'(homed), m_homed);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_eq("R1", "step in reset", int'(step), 0);
    chk_eq("R1", "dir in reset", int'(dir), 0);
    chk_eq("R1", "en_n in reset", int'(en_n), 1);
    chk_eq("R1", "pos in reset", int'(pos), 0);
    chk_eq("R1", "speed in reset", int'(speed), 0);
    chk_eq("R1", "homed in reset", int'(homed), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R1", "en_n after reset", int'(en_n), 0);
  endtask

  task automatic t_seek_start();
    do_tick();
    chk_eq("R2", "pos after first tick", int'(pos), 0);
    chk_eq("R2", "step after first tick", int'(step), 0);
    chk_eq("R2", "speed after first tick", int'(speed), 0);
    do_tick();
    chk_eq("R2", "speed second tick", int'(speed), 1);
    chk_eq("R10", "pos second tick", int'(pos), 1);
    chk_eq("R8", "step second tick", int'(step), 1);
    chk_eq("R9", "dir second tick", int'(dir), 1);
    repeat (119) do_tick();
    chk_eq("R7", "pos before interval ends", int'(pos), 1);
    do_tick();
    chk_eq("R7", "pos at interval end", int'(pos), 2);
    chk_eq("R5", "speed at interval end", int'(speed), 2);
  endtask

  task automatic t_seek_run();
    for (int i = 0; i < 200; i++) begin
      do_tick();
      compare_model("R5");
    end
  endtask

  task automatic t_home();
    target = 8'd0;
    home_n = 1'b0;
    do_tick();
    chk_eq("R3", "homed", int'(homed), 1);
    chk_eq("R3", "pos cleared", int'(pos), 0);
    chk_eq("R3", "speed cleared", int'(speed), 0);
  endtask

  task automatic t_idle();
    logic s0;
    s0 = step;
    for (int i = 0; i < 60; i++) do_tick();
    chk_eq("R11", "step held at zero target speed", int'(step), int'(s0));
    chk_eq("R11", "pos held at zero target speed", int'(pos), 0);
    chk_eq("R3", "home switch ignored once homed", int'(homed), 1);
    compare_model("R3");
    home_n = 1'b1;
    s0 = step;
    repeat (30) @(negedge clk);
    chk_eq("R12", "step stable without tick", int'(step), int'(s0));
  endtask

  task automatic t_follow();
    target = 8'd20;
    do_tick();
    chk_eq("R4", "pos on target change", int'(pos), 0);
    do_tick();
    chk_eq("R4", "pos one tick later", int'(pos), 1);
    chk_eq("R4", "speed one tick later", int'(speed), 1);
    for (int i = 0; i < 2500; i++) begin
      do_tick();
      compare_model("R4");
    end
    chk_eq("R4", "settled pos", int'(pos), 20);
  endtask

  task automatic t_reverse();
    logic s0;
    target = 8'd5;
    do_tick();
    chk_eq("R4", "pos on reversal request", int'(pos), 20);
    s0 = step;
    do_tick();
    chk_eq("R8", "speed at zero event", int'(speed), 0);
    chk_eq("R8", "pos at zero event", int'(pos), 20);
    chk_eq("R8", "step at zero event", int'(step), int'(s0));
    chk_eq("R9", "dir kept at zero speed", int'(dir), 1);
    do_tick();
    chk_eq("R9", "dir negative", int'(dir), 0);
    chk_eq("R10", "pos decrement", int'(pos), 19);
    chk_eq("R5", "speed negative", int'(speed), -1);
    chk_eq("R8", "step toggles", int'(step), int'(!s0));
    for (int i = 0; i < 2500; i++) begin
      do_tick();
      compare_model("R4");
    end
    chk_eq("R4", "settled pos reverse", int'(pos), 5);
  endtask

  task automatic t_clamp();
    int peak;
    peak = 0;
    target = 8'd255;
    for (int i = 0; i < 3000; i++) begin
      do_tick();
      compare_model("R6");
      if (int'(speed) > peak) peak = int'(speed);
    end
    chk_eq("R6", "peak speed", peak, MAXS);
    chk_eq("R4", "settled pos far", int'(pos), 255);
  endtask

  initial begin
    t_reset();
    t_seek_start();
    t_seek_run();
    t_home();
    t_idle();
    t_follow();
    t_reverse();
    t_clamp();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule